// File: doc/BRIEF.md
# Prioritized Shared-Pin Multiplexer

This block sits between a general-purpose I/O port and the pads it shares with several on-chip peripherals. For each pin it decides which function owns the pad. Every peripheral source has an enable. A fixed order resolves conflicts: a higher source index wins, and plain port use ranks below all sources. The owner's output-enable and output value go to the pad.

Ownership does not reach the port read path or the pull control. A port read is still steered by the port direction bit. The pull enable still switches on a pull device whenever the pad is not driving. On the keyboard-capable pins, the pull becomes a pull-down when two conditions hold: the keyboard-style source owns the pin, and it is set for rising-edge or high-level sensing.

The pad input passes through a synchronizer before any consumer sees it. A per-pin one-cycle strobe flags each change of owner, so software can clear flags that a spurious edge may have set.

Top module: `shared_pin_mux`

## Requirements
- R1: When one or more peripheral sources of a pin are enabled, the enabled source with the highest index drives `pad_oe` and `pad_out` from its own `periph_oe` and `periph_out` bits. Bit `p*NUM_SRC+s` of the source vectors belongs to pin p, source s.
- R2: When no source of a pin is enabled, the port owns the pin: `pad_oe` equals `port_dir` and `pad_out` equals `port_data`.
- R3: `port_read` returns `port_data` when `port_dir` is 1 and the synchronized pad level when `port_dir` is 0. This holds whichever function owns the pin.
- R4: A change on `pad_in` appears on `port_read` (with `port_dir`=0) and on `periph_in` after exactly SYNC_STAGES (default 2) rising clock edges.
- R5: When `pad_oe` is 0 and `port_pull_en` is 1, the pin gets a pull device, a pull-up unless R6 applies. When `port_pull_en` is 0, both pull outputs are 0.
- R6: On pins marked in KBD_PIN_MASK (default pins 0 and 1), the pull is a pull-down instead of a pull-up when source KBD_SRC (default 1) owns the pin and its `kbd_rise` bit is 1. On other pins, or with `kbd_rise`=0, it stays a pull-up.
- R7: `pad_pu` and `pad_pd` are never 1 together, and both are 0 whenever `pad_oe` is 1.
- R8: `own_change` for a pin is 1 during the cycle in which the pin's owner differs from the owner held at the previous clock edge, and 0 once the owner is stable. Toggling a source that stays outranked causes no strobe.
- R9: During reset the synchronizer holds 0, so `port_read` with `port_dir`=0 and `periph_in` read 0, and `own_change` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_data | input | NUM_PINS | Port data latch |
| port_dir | input | NUM_PINS | Port direction, 1 = output |
| port_pull_en | input | NUM_PINS | Pull device enable |
| periph_en | input | NUM_PINS*NUM_SRC | Per-source ownership request |
| periph_oe | input | NUM_PINS*NUM_SRC | Per-source output-buffer enable |
| periph_out | input | NUM_PINS*NUM_SRC | Per-source output value |
| kbd_rise | input | NUM_PINS | Keyboard sensing polarity, 1 = rising/high |
| pad_in | input | NUM_PINS | Raw pad level |
| pad_oe | output | NUM_PINS | Pad output-buffer enable |
| pad_out | output | NUM_PINS | Pad output value |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |
| port_read | output | NUM_PINS | Value returned on a port read |
| periph_in | output | NUM_PINS | Synchronized pad level for the peripherals |
| own_change | output | NUM_PINS | One-cycle ownership change strobe |

## Verification
A wrong owner index shows at once on `pad_oe` and `pad_out`, in the same cycle the enables change. It also pulls the pull outputs the wrong way on the keyboard pins. A stale previous-owner register shows as an `own_change` strobe that is missing or lasts too long; this is visible in the cycle of the change and the cycle after it. A short or long synchronizer shows up on `port_read` and `periph_in` one edge early or late after a pad step.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   typedef enum logic [1:0] {
      PULL_OFF  = 2'd0,
      PULL_UP   = 2'd1,
      PULL_DOWN = 2'd2
   } pull_mode_e;

   function automatic int owner_width(input int num_src);
      return (num_src < 1) ? 1 : $clog2(num_src + 1);
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar st = 0; st < STAGES; st++) begin : g_stage
         if (st == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[st] <= '0;
               else        chain[st] <= chain[st-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_arbiter.sv
module pin_arbiter #(
   parameter int NUM_SRC = 3,
   parameter int OWN_W   = pinmux_pkg::owner_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_en,
   output logic [OWN_W-1:0]   owner
);
   always_comb begin
      owner = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (src_en[s]) owner = OWN_W'(s + 1);
      end
   end

   assert_owner_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == '0) == (src_en == '0));
endmodule

// File: rtl/pin_pull_ctl.sv
module pin_pull_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic pull_en,
   input  logic drive_on,
   input  logic kbd_owned,
   input  logic kbd_rise,
   output logic pu,
   output logic pd
);
   import pinmux_pkg::*;

   pull_mode_e mode;

   always_comb begin
      if (!pull_en || drive_on)       mode = PULL_OFF;
      else if (kbd_owned && kbd_rise) mode = PULL_DOWN;
      else                            mode = PULL_UP;
   end

   assign pu = (mode == PULL_UP);
   assign pd = (mode == PULL_DOWN);

   assert_pull_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pu && pd));
endmodule

// File: rtl/pin_slice.sv
module pin_slice #(
   parameter int NUM_SRC     = 3,
   parameter int KBD_SRC     = 1,
   parameter bit KBD_CAPABLE = 1'b1,
   parameter int OWN_W       = pinmux_pkg::owner_width(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               port_data,
   input  logic               port_dir,
   input  logic               port_pull_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_oe,
   input  logic [NUM_SRC-1:0] src_out,
   input  logic               kbd_rise,
   input  logic               sync_in,
   output logic               pad_oe,
   output logic               pad_out,
   output logic               pad_pu,
   output logic               pad_pd,
   output logic               port_read,
   output logic               own_change
);
   logic [OWN_W-1:0] owner;
   logic [OWN_W-1:0] owner_q;
   logic             kbd_owned;

   pin_arbiter #(.NUM_SRC(NUM_SRC), .OWN_W(OWN_W)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_en (src_en),
      .owner  (owner)
   );

   always_comb begin
      pad_oe  = port_dir;
      pad_out = port_data;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (owner == OWN_W'(s + 1)) begin
            pad_oe  = src_oe[s];
            pad_out = src_out[s];
         end
      end
   end

   assign port_read = port_dir ? port_data : sync_in;

   generate
      if (KBD_CAPABLE) begin : g_kbd
         assign kbd_owned = (owner == OWN_W'(KBD_SRC + 1));
      end else begin : g_plain
         assign kbd_owned = 1'b0;
      end
   endgenerate

   pin_pull_ctl u_pull (
      .clk       (clk),
      .rst_n     (rst_n),
      .pull_en   (port_pull_en),
      .drive_on  (pad_oe),
      .kbd_owned (kbd_owned),
      .kbd_rise  (kbd_rise),
      .pu        (pad_pu),
      .pd        (pad_pd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= '0;
      else        owner_q <= owner;
   end

   assign own_change = (owner != owner_q);

   assert_pull_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe |-> (!pad_pu && !pad_pd));

   assert_pd_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pd |-> (kbd_owned && kbd_rise && port_pull_en));

   assert_strobe_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      own_change |=> (!own_change || !$stable(src_en)));
endmodule

// File: rtl/shared_pin_mux.sv
module shared_pin_mux #(
   parameter int              NUM_PINS     = 4,
   parameter int              NUM_SRC      = 3,
   parameter int              KBD_SRC      = 1,
   parameter logic [NUM_PINS-1:0] KBD_PIN_MASK = 4'b0011,
   parameter int              SYNC_STAGES  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PINS-1:0]          port_data,
   input  logic [NUM_PINS-1:0]          port_dir,
   input  logic [NUM_PINS-1:0]          port_pull_en,
   input  logic [NUM_PINS*NUM_SRC-1:0]  periph_en,
   input  logic [NUM_PINS*NUM_SRC-1:0]  periph_oe,
   input  logic [NUM_PINS*NUM_SRC-1:0]  periph_out,
   input  logic [NUM_PINS-1:0]          kbd_rise,
   input  logic [NUM_PINS-1:0]          pad_in,
   output logic [NUM_PINS-1:0]          pad_oe,
   output logic [NUM_PINS-1:0]          pad_out,
   output logic [NUM_PINS-1:0]          pad_pu,
   output logic [NUM_PINS-1:0]          pad_pd,
   output logic [NUM_PINS-1:0]          port_read,
   output logic [NUM_PINS-1:0]          periph_in,
   output logic [NUM_PINS-1:0]          own_change
);
   localparam int OWN_W = pinmux_pkg::owner_width(NUM_SRC);

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("NUM_PINS must be at least 1");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be at least 1");
      end
      if (KBD_SRC < 0 || KBD_SRC >= NUM_SRC) begin : g_bad_kbd
         $error("KBD_SRC must index an existing source");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] sync_lvl;

   pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_lvl)
   );

   assign periph_in = sync_lvl;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         pin_slice #(
            .NUM_SRC     (NUM_SRC),
            .KBD_SRC     (KBD_SRC),
            .KBD_CAPABLE (KBD_PIN_MASK[p]),
            .OWN_W       (OWN_W)
         ) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .port_data    (port_data[p]),
            .port_dir     (port_dir[p]),
            .port_pull_en (port_pull_en[p]),
            .src_en       (periph_en[p*NUM_SRC +: NUM_SRC]),
            .src_oe       (periph_oe[p*NUM_SRC +: NUM_SRC]),
            .src_out      (periph_out[p*NUM_SRC +: NUM_SRC]),
            .kbd_rise     (kbd_rise[p]),
            .sync_in      (sync_lvl[p]),
            .pad_oe       (pad_oe[p]),
            .pad_out      (pad_out[p]),
            .pad_pu       (pad_pu[p]),
            .pad_pd       (pad_pd[p]),
            .port_read    (port_read[p]),
            .own_change   (own_change[p])
         );
      end
   endgenerate

   assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (periph_in == '0));
endmodule

// File: tb/shared_pin_mux_test.sv
module shared_pin_mux_test;
   localparam int NP = 4;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    port_data = '0, port_dir = '0, port_pull_en = '0;
   logic [NP*NS-1:0] periph_en = '0, periph_oe = '0, periph_out = '0;
   logic [NP-1:0]    kbd_rise = '0, pad_in = '0;
   logic [NP-1:0]    pad_oe, pad_out, pad_pu, pad_pd, port_read, periph_in, own_change;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   shared_pin_mux uut (
      .clk(clk), .rst_n(rst_n), .port_data(port_data), .port_dir(port_dir),
      .port_pull_en(port_pull_en), .periph_en(periph_en), .periph_oe(periph_oe),
      .periph_out(periph_out), .kbd_rise(kbd_rise), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .port_read(port_read), .periph_in(periph_in), .own_change(own_change)
   );

   function automatic logic [NP*NS-1:0] rep(input logic [NS-1:0] bits);
      return {NP{bits}};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      pad_in = '1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R9", "port_read in reset", port_read, '0);
      chk("R9", "periph_in in reset", periph_in, '0);
      chk("R9", "own_change in reset", own_change, '0);
      rst_n = 1'b1;
      pad_in = '0;
      repeat (3) step();
   endtask

   task automatic t_port_owner();
      periph_en = '0;
      port_dir = 4'b1010; port_data = 4'b0110;
      #1;
      chk("R2", "pad_oe port owned", pad_oe, 4'b1010);
      chk("R2", "pad_out port owned", pad_out, 4'b0110);
      chk("R3", "port_read mixed dir", port_read, 4'b0010);
      step();
   endtask

   task automatic t_priority();
      // src0: oe=1 out=0 ; src1: oe=0 out=1 ; src2: oe=1 out=1
      periph_oe  = rep(3'b101);
      periph_out = rep(3'b110);
      periph_en  = rep(3'b001); #1;
      chk("R1", "src0 owns oe", pad_oe, '1);
      chk("R1", "src0 owns out", pad_out, '0);
      chk("R8", "strobe on port->src0", own_change, '1);
      step();
      chk("R8", "strobe ends", own_change, '0);
      periph_en = rep(3'b011); #1;
      chk("R1", "src1 over src0 oe", pad_oe, '0);
      chk("R1", "src1 over src0 out", pad_out, '1);
      chk("R8", "strobe src0->src1", own_change, '1);
      step();
      periph_en = rep(3'b111); #1;
      chk("R1", "src2 over all oe", pad_oe, '1);
      chk("R1", "src2 over all out", pad_out, '1);
      step();
      periph_en = rep(3'b110); #1;
      chk("R8", "no strobe when outranked source drops", own_change, '0);
      chk("R1", "src2 still owns", pad_oe, '1);
      step();
      periph_en = '0; #1;
      chk("R8", "strobe back to port", own_change, '1);
      chk("R2", "port regains pad_oe", pad_oe, port_dir);
      step();
      chk("R8", "quiet after return", own_change, '0);
   endtask

   task automatic t_read_path();
      periph_en = rep(3'b100);
      port_dir = '0; port_data = 4'b1010;
      pad_in = 4'b0101;
      repeat (3) step();
      chk("R3", "periph owns, dir=0 reads pad", port_read, 4'b0101);
      port_dir = '1; #1;
      chk("R3", "periph owns, dir=1 reads latch", port_read, 4'b1010);
      chk("R1", "pad still driven by src2", pad_oe, '1);
      periph_en = '0; port_dir = '0;
      repeat (2) step();
   endtask

   task automatic t_sync();
      port_dir = '0; pad_in = '0;
      repeat (3) step();
      pad_in = 4'b1111;
      step();
      chk("R4", "after one edge old value", port_read, '0);
      step();
      chk("R4", "after two edges new value", port_read, '1);
      chk("R4", "periph_in after two edges", periph_in, '1);
   endtask

   task automatic t_pull();
      periph_en = '0; port_dir = '0; port_pull_en = '1; kbd_rise = '1; #1;
      chk("R5", "port input pull-up", pad_pu, '1);
      chk("R5", "no pull-down port owned", pad_pd, '0);
      periph_en = rep(3'b010); #1;
      chk("R6", "kbd rise pull-down on kbd pins", pad_pd, 4'b0011);
      chk("R6", "pull-up on other pins", pad_pu, 4'b1100);
      kbd_rise = '0; #1;
      chk("R6", "falling sense keeps pull-up", pad_pu, '1);
      chk("R6", "falling sense no pull-down", pad_pd, '0);
      kbd_rise = '1; port_pull_en = '0; #1;
      chk("R5", "pull disabled pu", pad_pu, '0);
      chk("R5", "pull disabled pd", pad_pd, '0);
      port_pull_en = '1;
      periph_en = rep(3'b110); #1;
      chk("R7", "driving pad pu off", pad_pu, '0);
      chk("R7", "driving pad pd off", pad_pd, '0);
      periph_en = rep(3'b001); #1;
      chk("R6", "timer owns, no pull-down", pad_pd, '0);
      periph_en = '0; port_dir = '1; #1;
      chk("R7", "port output pulls off", pad_pu | pad_pd, '0);
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_port_owner();
      t_priority();
      t_read_path();
      t_sync();
      t_pull();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule